// File: doc/BRIEF.md
# JTAG Page-Buffer Byte Loader

This block sits behind a JTAG TAP controller and fills a flash page buffer one byte at a time while a page-load instruction is active. Serial data from TDI enters an 8-bit data register on each TCK edge that has the shift strobe high. The previous contents of that register leave on TDO at the same time. Each Update-DR strobe copies the register into a holding register and starts a fixed-length write sequence. When the sequence completes, the held byte goes into one half of a 16-bit page-buffer word.

Bytes go to the low half and the high half of a word in turn. A word counter is loaded from the start address when the instruction is entered. The counter steps forward just before every low-byte write, except the first one after entry. As a result, the first byte lands on the start word, and filling the last word of a page leaves the counter on that word.

The TAP controller and the flash array are outside this block. Its host sees only a one-cycle write pulse that carries the word address, the byte lane and the data.

Top module: `pgbuf_load_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pb_we`, `busy` and `tdo` are 0. The data register resets to all zeros.
- R2: On each TCK edge with `shift_dr` high, `tdi` enters the data register at its most significant bit. `tdo` shows the least significant bit. Eight shifts therefore push out the previous byte, least significant bit first. With `shift_dr` low, `tdo` does not change.
- R3: An accepted Update-DR raises `busy` from the next cycle onward. `pb_we` is high for exactly one cycle, LATENCY (default 11) TCK edges after the Update-DR edge. `busy` falls at that same edge.
- R4: `pb_data` during the `pb_we` pulse equals the data register contents at the Update-DR edge.
- R5: Byte lanes alternate on successive writes. The lane is low (`pb_lane`=0) for the first write after instruction entry and high (`pb_lane`=1) for the next.
- R6: The k-th byte written after entry (k counted from 0) goes to word `start_addr + k/2`, rounded down. The first low byte uses the start address without an increment.
- R7: Loading a word that starts at the highest address puts both of its bytes at that address. The counter does not move past the last word that was loaded.
- R8: An Update-DR that arrives while `busy` is high is ignored. It produces no write and it does not disturb the lane or address order.
- R9: Shifting while `busy` is high does not change the pending byte. A later accepted Update-DR with no new shift writes the byte that was shifted in.
- R10: An `instr_entry` pulse cancels any pending write, so no `pb_we` follows and `busy` is low after that edge. It also reloads the counter from `start_addr`, resets the lane to low and restores the first-byte rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_dr | input | 1 | TAP is in the shift state for this data register |
| update_dr | input | 1 | One-cycle Update-DR strobe |
| tdi | input | 1 | Serial data in |
| instr_entry | input | 1 | One-cycle pulse when the page-load instruction is entered |
| start_addr | input | ADDR_W | Word address set up before entry |
| tdo | output | 1 | Serial data out |
| busy | output | 1 | A write sequence is in progress |
| pb_we | output | 1 | One-cycle page-buffer write strobe |
| pb_addr | output | ADDR_W | Word address of the write |
| pb_lane | output | 1 | 0 = low byte, 1 = high byte |
| pb_data | output | DATA_W | Byte written |

## Verification
The bench builds the block with an 8-bit data register, an 11-cycle write latency and a 7-bit word address. The narrow address puts the highest word, 127, within reach, so a load that ends on the top word checks that the counter stays inside the loaded range. The full 11-cycle window leaves room to shift a complete new byte and fire an extra Update-DR while a write is still pending. It also leaves room to cancel a pending write with a fresh instruction entry partway through.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
   typedef enum logic {
      LANE_LO = 1'b0,
      LANE_HI = 1'b1
   } lane_e;
endpackage

// File: rtl/pgbuf_dr_shift.sv
module pgbuf_dr_shift #(
   parameter int DATA_W          = 8,
   parameter bit SHIFT_LSB_FIRST = 1'b1
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              tdi,
   input  logic              take,
   output logic              tdo,
   output logic [DATA_W-1:0] held
);
   logic [DATA_W-1:0] sr_q;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("pgbuf_dr_shift: DATA_W must be at least 2");
      end
      if (SHIFT_LSB_FIRST) begin : g_lsb_first
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n)        sr_q <= '0;
            else if (shift_en) sr_q <= {tdi, sr_q[DATA_W-1:1]};
         end
         assign tdo = sr_q[0];
      end else begin : g_msb_first
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n)        sr_q <= '0;
            else if (shift_en) sr_q <= {sr_q[DATA_W-2:0], tdi};
         end
         assign tdo = sr_q[DATA_W-1];
      end
   endgenerate

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)    held <= '0;
      else if (take) held <= sr_q;
   end
endmodule

// File: rtl/pgbuf_wr_timer.sv
module pgbuf_wr_timer #(
   parameter int LATENCY = 11
) (
   input  logic tck,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   output logic busy,
   output logic fire
);
   localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (LATENCY < 1) begin : g_bad_latency
         $error("pgbuf_wr_timer: LATENCY must be at least 1");
      end
   endgenerate

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (abort) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= CNT_LOAD;
      end else if (busy) begin
         if (cnt_q == '0) busy  <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign fire = busy && (cnt_q == '0);
endmodule

// File: rtl/pgbuf_addr_ctrl.sv
module pgbuf_addr_ctrl
   import pgbuf_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              entry,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              fire,
   input  logic [DATA_W-1:0] wdata,
   output logic              pb_we,
   output logic [ADDR_W-1:0] pb_addr,
   output logic              pb_lane,
   output logic [DATA_W-1:0] pb_data
);
   logic [ADDR_W-1:0] pc_q, pc_use;
   lane_e             lane_q;
   logic              first_q;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("pgbuf_addr_ctrl: ADDR_W must be at least 1");
      end
   endgenerate

   always_comb begin
      pc_use = pc_q;
      if (lane_q == LANE_LO && !first_q) pc_use = pc_q + 1'b1;
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         lane_q  <= LANE_LO;
         first_q <= 1'b1;
         pb_we   <= 1'b0;
         pb_addr <= '0;
         pb_lane <= 1'b0;
         pb_data <= '0;
      end else begin
         pb_we <= 1'b0;
         if (entry) begin
            pc_q    <= start_addr;
            lane_q  <= LANE_LO;
            first_q <= 1'b1;
         end else if (fire) begin
            pc_q    <= pc_use;
            pb_addr <= pc_use;
            pb_lane <= lane_q;
            pb_data <= wdata;
            pb_we   <= 1'b1;
            lane_q  <= (lane_q == LANE_LO) ? LANE_HI : LANE_LO;
            first_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pgbuf_load_seq.sv
module pgbuf_load_seq #(
   parameter int ADDR_W          = 16,
   parameter int DATA_W          = 8,
   parameter int LATENCY         = 11,
   parameter bit SHIFT_LSB_FIRST = 1'b1
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              shift_dr,
   input  logic              update_dr,
   input  logic              tdi,
   input  logic              instr_entry,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              tdo,
   output logic              busy,
   output logic              pb_we,
   output logic [ADDR_W-1:0] pb_addr,
   output logic              pb_lane,
   output logic [DATA_W-1:0] pb_data
);
   logic              accept;
   logic              fire;
   logic [DATA_W-1:0] held;

   assign accept = update_dr && !busy && !instr_entry;

   pgbuf_dr_shift #(.DATA_W(DATA_W), .SHIFT_LSB_FIRST(SHIFT_LSB_FIRST)) u_shift (
      .tck(tck), .rst_n(rst_n), .shift_en(shift_dr), .tdi(tdi),
      .take(accept), .tdo(tdo), .held(held)
   );

   pgbuf_wr_timer #(.LATENCY(LATENCY)) u_timer (
      .tck(tck), .rst_n(rst_n), .start(accept), .abort(instr_entry),
      .busy(busy), .fire(fire)
   );

   pgbuf_addr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
      .tck(tck), .rst_n(rst_n), .entry(instr_entry), .start_addr(start_addr),
      .fire(fire), .wdata(held), .pb_we(pb_we), .pb_addr(pb_addr),
      .pb_lane(pb_lane), .pb_data(pb_data)
   );
endmodule

// File: rtl/pgbuf_load_seq_chk.sv
module pgbuf_load_seq_chk (
   input logic tck,
   input logic rst_n,
   input logic shift_dr,
   input logic instr_entry,
   input logic tdo,
   input logic busy,
   input logic pb_we,
   input logic pb_lane
);
   logic exp_lane;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)           exp_lane <= 1'b0;
      else if (instr_entry) exp_lane <= 1'b0;
      else if (pb_we)       exp_lane <= ~exp_lane;
   end

   a_r2_tdo_hold: assert property (@(posedge tck) disable iff (!rst_n)
      !shift_dr |=> $stable(tdo));

   a_r3_we_one_cycle: assert property (@(posedge tck) disable iff (!rst_n)
      pb_we |=> !pb_we);

   a_r3_we_ends_busy: assert property (@(posedge tck) disable iff (!rst_n)
      pb_we |-> ($past(busy) && !busy));

   a_r3_busy_exit_writes: assert property (@(posedge tck) disable iff (!rst_n)
      ($fell(busy) && !$past(instr_entry)) |-> pb_we);

   a_r5_lane_alternates: assert property (@(posedge tck) disable iff (!rst_n)
      pb_we |-> (pb_lane == exp_lane));

   a_r10_entry_cancels: assert property (@(posedge tck) disable iff (!rst_n)
      instr_entry |=> (!pb_we && !busy));
endmodule

bind pgbuf_load_seq pgbuf_load_seq_chk i_chk (
   .tck(tck), .rst_n(rst_n), .shift_dr(shift_dr), .instr_entry(instr_entry),
   .tdo(tdo), .busy(busy), .pb_we(pb_we), .pb_lane(pb_lane)
);

// File: tb/test_pgbuf_load_seq.sv
module test_pgbuf_load_seq;
   localparam int AW = 7;
   localparam int DW = 8;
   localparam int LAT = 11;

   logic tck = 1'b0, rst_n = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
   logic tdi = 1'b0, instr_entry = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic tdo, busy, pb_we, pb_lane;
   logic [AW-1:0] pb_addr;
   logic [DW-1:0] pb_data;

   int n_checks = 0, n_fail = 0, cyc = 0;
   logic [DW-1:0] last_byte = '0;

   typedef struct {
      logic [AW-1:0] a;
      logic          l;
      logic [DW-1:0] d;
      int            c;
      string         r;
   } exp_t;
   exp_t q[$];

   always #4 tck = ~tck;
   always @(posedge tck) cyc <= cyc + 1;

   pgbuf_load_seq #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT)) i_pgbuf_load_seq (
      .tck(tck), .rst_n(rst_n), .shift_dr(shift_dr), .update_dr(update_dr),
      .tdi(tdi), .instr_entry(instr_entry), .start_addr(start_addr),
      .tdo(tdo), .busy(busy), .pb_we(pb_we), .pb_addr(pb_addr),
      .pb_lane(pb_lane), .pb_data(pb_data)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: compares every write pulse with the scoreboard head
   always @(negedge tck) begin
      if (rst_n && pb_we) begin
         if (q.size() == 0) begin
            check(1'b0, "R8/R10", "unexpected write at addr", int'(pb_addr), -1);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(pb_addr == e.a, e.r, "write address", int'(pb_addr), int'(e.a));
            check(pb_lane == e.l, "R5", "byte lane", int'(pb_lane), int'(e.l));
            check(pb_data == e.d, "R4", "write data", int'(pb_data), int'(e.d));
            check(cyc == e.c, "R3", "write cycle", cyc, e.c);
         end
      end
   end

   task automatic shift_byte(input logic [DW-1:0] b);
      logic [DW-1:0] out;
      for (int i = 0; i < DW; i++) begin
         @(negedge tck);
         out[i] = tdo;
         shift_dr = 1'b1;
         tdi = b[i];
      end
      @(negedge tck);
      shift_dr = 1'b0;
      check(out == last_byte, "R2", "tdo shifted out previous byte", int'(out), int'(last_byte));
      last_byte = b;
   endtask

   task automatic pulse_update(input bit push, input logic [AW-1:0] a,
                               input logic l, input logic [DW-1:0] d, input string r);
      exp_t e;
      @(negedge tck);
      update_dr = 1'b1;
      @(negedge tck);
      update_dr = 1'b0;
      if (push) begin
         e.a = a; e.l = l; e.d = d; e.c = cyc + LAT; e.r = r;
         q.push_back(e);
         check(busy == 1'b1, "R3", "busy after update", int'(busy), 1);
      end
   endtask

   task automatic enter(input logic [AW-1:0] a);
      @(negedge tck);
      instr_entry = 1'b1;
      start_addr = a;
      @(negedge tck);
      instr_entry = 1'b0;
      check(busy == 1'b0 && pb_we == 1'b0, "R10", "idle after entry",
            int'({busy, pb_we}), 0);
   endtask

   task automatic wait_idle();
      while (busy || q.size() != 0) @(negedge tck);
      @(negedge tck);
   endtask

   task automatic load(input logic [DW-1:0] b, input logic [AW-1:0] a,
                       input logic l, input string r);
      shift_byte(b);
      pulse_update(1'b1, a, l, b, r);
      wait_idle();
   endtask

   initial begin
      repeat (200000) @(posedge tck);
      check(1'b0, "WDOG", "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge tck);
      check(pb_we == 0 && busy == 0 && tdo == 0, "R1", "outputs in reset",
            int'({pb_we, busy, tdo}), 0);
      rst_n = 1'b1;
      @(negedge tck);
      check(pb_we == 0 && busy == 0 && tdo == 0, "R1", "outputs after reset",
            int'({pb_we, busy, tdo}), 0);

      // R6 sequential loading, R5 lane order
      enter(7'd10);
      load(8'hA1, 7'd10, 1'b0, "R6");
      load(8'h00, 7'd10, 1'b1, "R6");
      load(8'hFF, 7'd11, 1'b0, "R6");
      load(8'h5A, 7'd11, 1'b1, "R6");

      // R2: tdo stable while not shifting
      begin
         logic t0;
         t0 = tdo;
         repeat (4) @(negedge tck);
         check(tdo == t0, "R2", "tdo held without shift", int'(tdo), int'(t0));
      end

      // R8 and R9: update while busy ignored, shifting while busy keeps pending byte
      shift_byte(8'hC3);
      pulse_update(1'b1, 7'd12, 1'b0, 8'hC3, "R9");
      shift_byte(8'h3C);
      check(busy == 1'b1, "R8", "still busy before extra update", int'(busy), 1);
      pulse_update(1'b0, '0, 1'b0, '0, "R8");
      wait_idle();
      pulse_update(1'b1, 7'd12, 1'b1, 8'h3C, "R8");
      wait_idle();

      // R10: cancel a pending write, restart at a new address
      enter(7'd20);
      shift_byte(8'h77);
      pulse_update(1'b0, '0, 1'b0, '0, "R10");
      repeat (3) @(negedge tck);
      enter(7'd30);
      repeat (LAT + 4) @(negedge tck);
      check(q.size() == 0 && busy == 0, "R10", "no write after cancel", int'(busy), 0);
      load(8'h88, 7'd30, 1'b0, "R10");
      load(8'h99, 7'd30, 1'b1, "R10");

      // R10: entry after a lone low byte resets lane
      enter(7'd40);
      load(8'h12, 7'd40, 1'b0, "R10");
      enter(7'd50);
      load(8'h34, 7'd50, 1'b0, "R10");

      // R7: loading ends on the highest word
      enter(7'd126);
      load(8'h01, 7'd126, 1'b0, "R7");
      load(8'h02, 7'd126, 1'b1, "R7");
      load(8'h03, 7'd127, 1'b0, "R7");
      load(8'h04, 7'd127, 1'b1, "R7");
      enter(7'd127);
      load(8'hE1, 7'd127, 1'b0, "R7");
      load(8'hE2, 7'd127, 1'b1, "R7");

      repeat (5) @(negedge tck);
      check(q.size() == 0, "R3", "all writes seen", q.size(), 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule